// File: doc/BRIEF.md
# Eight-Channel Thermal and Supply Protection Gate

This block sits between the command register of an eight-channel high-side switch and its output drivers. For every channel it receives the commanded on/off state and a digitised junction temperature, and it receives one digitised reading of the output-side supply. It passes each command through to the channel's driver only while that channel is cool and the supply is healthy. It also produces one active-low diagnostic flag for the host.

Each channel keeps its own thermal state with hysteresis. An overheated channel is forced off and restarts by itself once it has cooled far enough. The other channels keep running. The supply is watched with a two-threshold lockout: it shuts every channel off when the supply sags and releases them once the supply has clearly recovered. No new command is needed for either kind of restart.

Temperatures arrive as unsigned 8-bit codes in degrees Celsius. The supply arrives as a 10-bit code in 50 mV steps. Protection state updates on the rising clock edge. The gated drive and the diagnostic are combinational from that state and the present command.

Top module: `prot_gate_top`

## Requirements
- R1: After synchronous reset every channel is marked cool and the supply is marked low. Every `drive_o` bit is 0 and `diag_n_o` is 0 until a clock edge sees `vbb_code_i` above the restart level.
- R2: While the supply is healthy and a channel is cool, `drive_o[i]` follows `cmd_i[i]` in the same cycle.
- R3: A channel whose temperature code (bits `8*i+7 .. 8*i` of `temp_i`) is 135 or more at a clock edge becomes tripped. Its drive is 0 after that edge. A code of 134 does not trip it.
- R4: A tripped channel stays tripped while its code is above 125. It returns to cool at the first edge where its code is 125 or less, and its drive then follows its command again.
- R5: Tripping or cooling one channel changes no other channel's drive.
- R6: A command of 0 does not clear a trip. A channel tripped, commanded off and then commanded on again stays off until the rule in R4 clears it.
- R7: `diag_n_o` is 0 exactly when at least one channel is tripped or the supply is marked low. Otherwise it is 1.
- R8: A healthy supply becomes low at an edge where `vbb_code_i` is below 200 (10.0 V). All drives are then 0. A code of exactly 200 keeps it healthy.
- R9: A low supply becomes healthy at an edge where `vbb_code_i` is above 210 (10.5 V). A code of exactly 210 keeps it low. On recovery, drives return to the present commands without any new command.
- R10: Channel thermal state keeps updating while the supply is low. A channel that heats during a supply dip is still tripped when the supply recovers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 8 | Commanded state per channel, 1 = on |
| temp_i | input | 64 | Junction temperature codes, channel i in bits 8*i+7..8*i, unsigned °C |
| vbb_code_i | input | 10 | Output supply reading, 50 mV per LSB |
| drive_o | output | 8 | Gated drive per channel, 1 = switch on |
| diag_n_o | output | 1 | Common diagnostic, low on any trip or supply-low |

## Verification
The case that is hardest to reach from the ports is a channel that is tripped, commanded off and partly cooled, and then commanded on again. Only the internal trip state, seen through `drive_o` and `diag_n_o`, shows that the trip survived. The stimulus heats one channel past the trip point, drops its command while holding its temperature inside the hysteresis band, then restores the command and checks that the channel is still off. The run also combines a supply dip with a hot channel in the same edge, so the two faults overlap and then recover in separate steps.

// File: rtl/prot_pkg.sv
package prot_pkg;

    localparam int DEF_NCH       = 8;
    localparam int DEF_TW        = 8;
    localparam int DEF_VW        = 10;
    localparam int DEF_TRIP      = 135;
    localparam int DEF_HYST      = 10;
    localparam int DEF_V_SHUT    = 200;
    localparam int DEF_V_RESTART = 210;

    typedef enum logic {
        TH_COOL    = 1'b0,
        TH_TRIPPED = 1'b1
    } th_state_e;

    typedef enum logic {
        SUP_LOW = 1'b0,
        SUP_OK  = 1'b1
    } sup_state_e;

    // next thermal state given present state and temperature comparisons
    function automatic th_state_e th_next(th_state_e cur, logic at_trip, logic at_cool);
        th_state_e nxt;
        nxt = cur;
        case (cur)
            TH_COOL:    if (at_trip) nxt = TH_TRIPPED;
            TH_TRIPPED: if (at_cool) nxt = TH_COOL;
            default:    nxt = TH_COOL;
        endcase
        return nxt;
    endfunction

    // next supply state given present state and voltage comparisons
    function automatic sup_state_e sup_next(sup_state_e cur, logic below_shut, logic above_restart);
        sup_state_e nxt;
        nxt = cur;
        case (cur)
            SUP_OK:  if (below_shut) nxt = SUP_LOW;
            SUP_LOW: if (above_restart) nxt = SUP_OK;
            default: nxt = SUP_LOW;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/prot_thermal_ch.sv
module prot_thermal_ch
    import prot_pkg::*;
#(
    parameter int TW = DEF_TW,
    parameter logic [TW-1:0] TRIP_C = TW'(DEF_TRIP),
    parameter logic [TW-1:0] COOL_C = TW'(DEF_TRIP - DEF_HYST)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [TW-1:0] temp,
    output logic          tripped
);

    th_state_e state_q;
    logic      at_trip;
    logic      at_cool;

    assign at_trip = (temp >= TRIP_C);
    assign at_cool = (temp <= COOL_C);

    always_ff @(posedge clk) begin
        if (rst) state_q <= TH_COOL;
        else     state_q <= th_next(state_q, at_trip, at_cool);
    end

    assign tripped = (state_q == TH_TRIPPED);

endmodule

// File: rtl/prot_supply_mon.sv
module prot_supply_mon
    import prot_pkg::*;
#(
    parameter int VW = DEF_VW,
    parameter logic [VW-1:0] SHUT_C    = VW'(DEF_V_SHUT),
    parameter logic [VW-1:0] RESTART_C = VW'(DEF_V_RESTART)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [VW-1:0] vcode,
    output logic          supply_low
);

    sup_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) state_q <= SUP_LOW;
        else     state_q <= sup_next(state_q, vcode < SHUT_C, vcode > RESTART_C);
    end

    assign supply_low = (state_q == SUP_LOW);

endmodule

// File: rtl/prot_out_gate.sv
module prot_out_gate #(
    parameter int NCH = 8
) (
    input  logic [NCH-1:0] cmd,
    input  logic [NCH-1:0] tripped,
    input  logic           supply_low,
    output logic [NCH-1:0] drive,
    output logic           diag_n
);

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            drive[i] = cmd[i] && !tripped[i] && !supply_low;
        end
    end

    assign diag_n = !((|tripped) || supply_low);

endmodule

// File: rtl/prot_gate_top.sv
module prot_gate_top
    import prot_pkg::*;
#(
    parameter int NCH       = DEF_NCH,
    parameter int TW        = DEF_TW,
    parameter int VW        = DEF_VW,
    parameter int TRIP      = DEF_TRIP,
    parameter int HYST      = DEF_HYST,
    parameter int V_SHUT    = DEF_V_SHUT,
    parameter int V_RESTART = DEF_V_RESTART
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NCH-1:0]    cmd_i,
    input  logic [NCH*TW-1:0] temp_i,
    input  logic [VW-1:0]     vbb_code_i,
    output logic [NCH-1:0]    drive_o,
    output logic              diag_n_o
);

    localparam logic [TW-1:0] TRIP_C    = TW'(TRIP);
    localparam logic [TW-1:0] COOL_C    = TW'(TRIP - HYST);
    localparam logic [VW-1:0] SHUT_C    = VW'(V_SHUT);
    localparam logic [VW-1:0] RESTART_C = VW'(V_RESTART);

    logic [NCH-1:0] tripped;
    logic           supply_low;

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        prot_thermal_ch #(
            .TW    (TW),
            .TRIP_C(TRIP_C),
            .COOL_C(COOL_C)
        ) u_th (
            .clk    (clk),
            .rst    (rst),
            .temp   (temp_i[g*TW +: TW]),
            .tripped(tripped[g])
        );
    end

    prot_supply_mon #(
        .VW       (VW),
        .SHUT_C   (SHUT_C),
        .RESTART_C(RESTART_C)
    ) u_sup (
        .clk       (clk),
        .rst       (rst),
        .vcode     (vbb_code_i),
        .supply_low(supply_low)
    );

    prot_out_gate #(
        .NCH(NCH)
    ) u_gate (
        .cmd       (cmd_i),
        .tripped   (tripped),
        .supply_low(supply_low),
        .drive     (drive_o),
        .diag_n    (diag_n_o)
    );

endmodule

// File: rtl/prot_gate_chk.sv
module prot_gate_chk #(
    parameter int NCH       = 8,
    parameter int TW        = 8,
    parameter int VW        = 10,
    parameter int TRIP      = 135,
    parameter int HYST      = 10,
    parameter int V_SHUT    = 200,
    parameter int V_RESTART = 210
) (
    input logic              clk,
    input logic              rst,
    input logic [NCH-1:0]    cmd_i,
    input logic [NCH*TW-1:0] temp_i,
    input logic [VW-1:0]     vbb_code_i,
    input logic [NCH-1:0]    drive_o,
    input logic              diag_n_o
);

    localparam logic [TW-1:0] TRIP_C    = TW'(TRIP);
    localparam logic [TW-1:0] COOL_C    = TW'(TRIP - HYST);
    localparam logic [VW-1:0] SHUT_C    = VW'(V_SHUT);
    localparam logic [VW-1:0] RESTART_C = VW'(V_RESTART);

    logic [NCH-1:0] all_cool;
    logic [NCH-1:0] hot_now;
    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            all_cool[i] = (temp_i[i*TW +: TW] <= COOL_C);
            hot_now[i]  = (temp_i[i*TW +: TW] >= TRIP_C);
        end
    end

    // R2
    no_uncommanded_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (drive_o & ~cmd_i) == '0);

    // R3
    for (genvar g = 0; g < NCH; g++) begin : g_trip
        trip_off_chk: assert property (@(posedge clk) disable iff (rst)
            hot_now[g] |=> !drive_o[g]);
    end

    // R7
    diag_on_hot_chk: assert property (@(posedge clk) disable iff (rst)
        (|hot_now) |=> !diag_n_o);

    // R7
    diag_clear_means_pass_chk: assert property (@(posedge clk) disable iff (rst)
        diag_n_o |-> (drive_o == cmd_i));

    // R8
    uv_shutdown_chk: assert property (@(posedge clk) disable iff (rst)
        (vbb_code_i < SHUT_C) |=> (drive_o == '0 && !diag_n_o));

    // R9
    recover_chk: assert property (@(posedge clk) disable iff (rst)
        (vbb_code_i > RESTART_C && (&all_cool)) |=> (diag_n_o && drive_o == cmd_i));

endmodule

bind prot_gate_top prot_gate_chk #(
    .NCH      (NCH),
    .TW       (TW),
    .VW       (VW),
    .TRIP     (TRIP),
    .HYST     (HYST),
    .V_SHUT   (V_SHUT),
    .V_RESTART(V_RESTART)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_i     (cmd_i),
    .temp_i    (temp_i),
    .vbb_code_i(vbb_code_i),
    .drive_o   (drive_o),
    .diag_n_o  (diag_n_o)
);

// File: tb/sim_prot_gate_top.sv
`timescale 1ns/1ps
module sim_prot_gate_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  cmd_i = '0;
    logic [63:0] temp_i = '0;
    logic [9:0]  vbb_code_i = '0;
    logic [7:0]  drive_o;
    logic        diag_n_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    prot_gate_top u0 (
        .clk       (clk),
        .rst       (rst),
        .cmd_i     (cmd_i),
        .temp_i    (temp_i),
        .vbb_code_i(vbb_code_i),
        .drive_o   (drive_o),
        .diag_n_o  (diag_n_o)
    );

    typedef struct packed {
        logic [7:0] cmd;
        logic [7:0] base_t;
        logic [2:0] hot_ch;
        logic [7:0] hot_t;
        logic [9:0] vcode;
        logic [7:0] exp_drive;
        logic       exp_diag;
        logic [7:0] req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t TBL [NV] = '{
        '{8'hFF, 8'd25, 3'd0, 8'd25,  10'd205, 8'h00, 1'b0, 8'd9},  // R9 band from reset
        '{8'hFF, 8'd25, 3'd0, 8'd25,  10'd211, 8'hFF, 1'b1, 8'd9},  // R9 release
        '{8'hA5, 8'd25, 3'd0, 8'd25,  10'd211, 8'hA5, 1'b1, 8'd2},  // R2
        '{8'hA5, 8'd25, 3'd0, 8'd25,  10'd200, 8'hA5, 1'b1, 8'd8},  // R8 edge
        '{8'hA5, 8'd25, 3'd0, 8'd25,  10'd199, 8'h00, 1'b0, 8'd8},  // R8
        '{8'hA5, 8'd25, 3'd0, 8'd25,  10'd210, 8'h00, 1'b0, 8'd9},  // R9 edge
        '{8'hA5, 8'd25, 3'd0, 8'd25,  10'd211, 8'hA5, 1'b1, 8'd9},  // R9 auto
        '{8'hFF, 8'd40, 3'd3, 8'd134, 10'd300, 8'hFF, 1'b1, 8'd3},  // R3 edge
        '{8'hFF, 8'd40, 3'd3, 8'd135, 10'd300, 8'hF7, 1'b0, 8'd3},  // R3 R5
        '{8'hFF, 8'd40, 3'd3, 8'd126, 10'd300, 8'hF7, 1'b0, 8'd4},  // R4 band
        '{8'hFF, 8'd40, 3'd3, 8'd125, 10'd300, 8'hFF, 1'b1, 8'd4},  // R4 cool
        '{8'hFF, 8'd40, 3'd3, 8'd200, 10'd300, 8'hF7, 1'b0, 8'd5},  // R5
        '{8'hF7, 8'd40, 3'd3, 8'd130, 10'd300, 8'hF7, 1'b0, 8'd6},  // R6 off
        '{8'hFF, 8'd40, 3'd3, 8'd130, 10'd300, 8'hF7, 1'b0, 8'd6},  // R6 back on
        '{8'hFF, 8'd40, 3'd3, 8'd100, 10'd300, 8'hFF, 1'b1, 8'd4},  // R4
        '{8'hFF, 8'd40, 3'd6, 8'd140, 10'd150, 8'h00, 1'b0, 8'd10}, // R10 both
        '{8'hFF, 8'd40, 3'd6, 8'd140, 10'd215, 8'hBF, 1'b0, 8'd10}, // R10 still hot
        '{8'hFF, 8'd40, 3'd6, 8'd60,  10'd215, 8'hFF, 1'b1, 8'd7}   // R7 clear
    };

    function automatic logic [63:0] temps(input logic [7:0] base, input logic [2:0] ch,
                                          input logic [7:0] hot);
        logic [63:0] t;
        for (int i = 0; i < 8; i++) t[i*8 +: 8] = (i == int'(ch)) ? hot : base;
        return t;
    endfunction

    task automatic check(input string req, input logic [7:0] ed, input logic edg);
        n_cmp++;
        if (drive_o !== ed || diag_n_o !== edg) begin
            n_bad++;
            $display("FAIL %s: drive=%h diag_n=%b expected drive=%h diag_n=%b",
                     req, drive_o, diag_n_o, ed, edg);
        end
    endtask

    task automatic step(input logic [7:0] c, input logic [63:0] t, input logic [9:0] v);
        cmd_i = c;
        temp_i = t;
        vbb_code_i = v;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        cmd_i = 8'hFF;
        temp_i = temps(8'd25, 3'd0, 8'd25);
        vbb_code_i = 10'd300;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 in reset", 8'h00, 1'b0);
        rst = 1'b0;
        // R1: supply starts low, only an edge with code above restart releases it
        check("R1 after release", 8'h00, 1'b0);

        for (int k = 0; k < NV; k++) begin
            string tag;
            step(TBL[k].cmd, temps(TBL[k].base_t, TBL[k].hot_ch, TBL[k].hot_t), TBL[k].vcode);
            tag = $sformatf("R%0d vec%0d", TBL[k].req, k);
            check(tag, TBL[k].exp_drive, TBL[k].exp_diag);
        end

        // R1: reset mid-run returns to supply-low and cool
        rst = 1'b1;
        step(8'hFF, temps(8'd40, 3'd2, 8'd150), 10'd300);
        rst = 1'b0;
        check("R1 mid-run reset", 8'h00, 1'b0);
        step(8'h3C, temps(8'd40, 3'd2, 8'd40), 10'd300);
        check("R2 after reset", 8'h3C, 1'b1);

        // R5: every channel hot at once, then cool one at a time
        step(8'hFF, {8{8'd180}}, 10'd300);
        check("R5 all hot", 8'h00, 1'b0);
        step(8'hFF, {{7{8'd180}}, 8'd20}, 10'd300);
        check("R5 ch0 cooled", 8'h01, 1'b0);
        step(8'hFF, {8{8'd125}}, 10'd300);
        check("R7 all cooled", 8'hFF, 1'b1);

        // R6: command off never clears, cooling while off does
        step(8'hFF, temps(8'd30, 3'd7, 8'd136), 10'd300);
        check("R6 ch7 hot", 8'h7F, 1'b0);
        step(8'h7F, temps(8'd30, 3'd7, 8'd120), 10'd300);
        check("R6 cooled while off", 8'h7F, 1'b1);
        step(8'hFF, temps(8'd30, 3'd7, 8'd120), 10'd300);
        check("R6 back on", 8'hFF, 1'b1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule